// File: doc/BRIEF.md
# NAND Flash Controller Status and Interrupt Register

This block is the 32-bit status word of a NAND flash controller. It brings together live levels (the ready/busy line from the flash, the two chip-enable outputs that the controller drives, and a flag saying that the boot copy has finished) and three sticky event flags. The event flags record a ready/busy transition, the end of an ECC decode, and an attempt to program or erase a protected region.

The ready/busy line arrives asynchronously. It passes through a two-flop synchronizer, and a transition is detected by comparing the newest synchronized sample with the one before it. A mode input chooses whether the rising or the falling transition counts. Software reads the word over a simple register bus and clears a sticky flag by writing 1 to its bit. Each flag has its own interrupt enable, and the single interrupt request stays high while any enabled flag is set.

Top module: `nand_stat_regs`

## Requirements
- R1: Bit 0 of `rdata_o` shows `rb_pin_i` after the two-flop synchronizer, so it follows the pin two rising clock edges later. 1 means ready and 0 means busy.
- R2: Bits 2 and 3 of `rdata_o` show `ce_lvl_i[0]` and `ce_lvl_i[1]` directly, with no clock delay.
- R3: Bit 4 is set on the clock edge after the synchronized ready/busy value changes in the selected direction. `edge_sel_i`=0 selects low to high and `edge_sel_i`=1 selects high to low. A change in the other direction does not set it.
- R4: Bit 5 is set on the clock edge after `prot_viol_i` is high.
- R5: Bit 6 is set on the clock edge after `ecc_done_i` is high.
- R6: Bit 23 shows `boot_done_i` directly.
- R7: Once set, bits 4, 5 and 6 stay set until a write (`sel_i` and `wr_i` high) carries 1 in that bit position, which clears the flag at that clock edge. A write that carries 0 in a flag's position leaves the flag unchanged.
- R8: If a flag's set event and its write-1 clear arrive in the same cycle, the flag ends up set.
- R9: Bits 1, 7 to 22 and 24 to 31 always read 0. Writes to those bits, or to bits 0, 2, 3 and 23, change nothing.
- R10: `irq_o` is the OR of the three flag-and-enable terms: bit 4 AND `irq_en_i[0]`, bit 5 AND `irq_en_i[1]`, and bit 6 AND `irq_en_i[2]`. It responds to the enables with no clock delay.
- R11: While `rst_n` is low, all flags are 0 and the synchronizer holds "ready" (1). Leaving reset therefore raises no transition event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rb_pin_i | input | 1 | Asynchronous ready/busy level from the flash |
| ce_lvl_i | input | 2 | Levels of the two chip-enable outputs |
| boot_done_i | input | 1 | Boot area copy finished |
| ecc_done_i | input | 1 | ECC decode finished, one-cycle pulse |
| prot_viol_i | input | 1 | Program or erase attempted on a protected region, pulse |
| edge_sel_i | input | 1 | Transition direction: 0 means low to high, 1 means high to low |
| irq_en_i | input | 3 | Interrupt enables for the transition, violation and ECC flags |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe (write 1 to clear) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The ready/busy line is toggled in both directions under each setting of `edge_sel_i`. A flag that is set only by the chosen direction shows that the direction is decoded correctly and that the synchronizer delay matches. The pulses are given with their flag's enable both off and on, which separates the sticky state from the interrupt gating. The write patterns compare a 1 with a 0 in each flag position, a write of all ones to the read-only and reserved bits, and a clear in the same cycle as a set. A long pseudo-random run of all the inputs is then compared with the reference model on every clock.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned N_FLAGS  = 3;
    localparam int unsigned N_CE     = 2;
    localparam int unsigned BIT_RB   = 0;
    localparam int unsigned BIT_CE0  = 2;
    localparam int unsigned BIT_FLG0 = 4;
    localparam int unsigned BIT_BOOT = 23;

    // flag order inside the flag vector (also the bit order above BIT_FLG0)
    localparam int unsigned FLG_EDGE = 0;
    localparam int unsigned FLG_PROT = 1;
    localparam int unsigned FLG_ECC  = 2;

    localparam logic [WORD_W-1:0] RSVD_MASK = 32'hFF7F_FF82;
endpackage

// File: rtl/nfs_rb_sync.sv
module nfs_rb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic level_o,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign edge_o  = fall_sel_i ? (st_q.prev & ~level_o)
                                : (~st_q.prev & level_o);
endmodule

// File: rtl/nfs_sticky.sv
module nfs_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = set_i | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/nand_stat_regs.sv
module nand_stat_regs
    import nfs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rb_pin_i,
    input  logic [N_CE-1:0]      ce_lvl_i,
    input  logic                 boot_done_i,
    input  logic                 ecc_done_i,
    input  logic                 prot_viol_i,
    input  logic                 edge_sel_i,
    input  logic [N_FLAGS-1:0]   irq_en_i,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 irq_o
);
    logic               rb_level;
    logic               rb_edge;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] clr_vec;
    logic [N_FLAGS-1:0] flags;
    logic               wr_hit;

    nfs_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (rb_pin_i),
        .fall_sel_i(edge_sel_i),
        .level_o   (rb_level),
        .edge_o    (rb_edge)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_EDGE] = rb_edge;
        set_vec[FLG_PROT] = prot_viol_i;
        set_vec[FLG_ECC]  = ecc_done_i;
        wr_hit            = sel_i & wr_i;
        clr_vec           = wdata_i[BIT_FLG0 +: N_FLAGS] & {N_FLAGS{wr_hit}};
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        nfs_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[g]),
            .clr_i (clr_vec[g]),
            .flag_o(flags[g])
        );
    end

    always_comb begin
        rdata_o                        = '0;
        rdata_o[BIT_RB]                = rb_level;
        rdata_o[BIT_CE0 +: N_CE]       = ce_lvl_i;
        rdata_o[BIT_FLG0 +: N_FLAGS]   = flags;
        rdata_o[BIT_BOOT]              = boot_done_i;
        irq_o                          = |(flags & irq_en_i);
    end
endmodule

// File: rtl/nfs_stat_chk.sv
module nfs_stat_chk
    import nfs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ecc_done_i,
    input logic               prot_viol_i,
    input logic [N_FLAGS-1:0] irq_en_i,
    input logic               sel_i,
    input logic               wr_i,
    input logic [WORD_W-1:0]  wdata_i,
    input logic [WORD_W-1:0]  rdata_o,
    input logic               irq_o
);
    logic wr_hit;
    assign wr_hit = sel_i & wr_i;

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & RSVD_MASK) == '0);

    assert_ecc_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_done_i |=> rdata_o[BIT_FLG0 + FLG_ECC]);

    assert_prot_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol_i |=> rdata_o[BIT_FLG0 + FLG_PROT]);

    assert_ecc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[BIT_FLG0 + FLG_ECC] && !(wr_hit && wdata_i[BIT_FLG0 + FLG_ECC]))
        |=> rdata_o[BIT_FLG0 + FLG_ECC]);

    assert_ecc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata_i[BIT_FLG0 + FLG_ECC] && !ecc_done_i)
        |=> !rdata_o[BIT_FLG0 + FLG_ECC]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata_i[BIT_FLG0 + FLG_PROT] && prot_viol_i)
        |=> rdata_o[BIT_FLG0 + FLG_PROT]);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(rdata_o[BIT_FLG0 +: N_FLAGS] & irq_en_i));
endmodule

bind nand_stat_regs nfs_stat_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecc_done_i (ecc_done_i),
    .prot_viol_i(prot_viol_i),
    .irq_en_i   (irq_en_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
);

// File: tb/tb_nand_stat_regs.sv
module tb_nand_stat_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        rb_pin_i = 1;
    logic [1:0]  ce_lvl_i = 2'b11;
    logic        boot_done_i = 0;
    logic        ecc_done_i = 0;
    logic        prot_viol_i = 0;
    logic        edge_sel_i = 0;
    logic [2:0]  irq_en_i = 0;
    logic        sel_i = 0;
    logic        wr_i = 0;
    logic [31:0] wdata_i = 0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nand_stat_regs dut (.*);

    // reference model: pin history queue, newest first
    bit hist[$];
    bit m_edge, m_prot, m_ecc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{1, 1, 1};
            m_edge = 0; m_prot = 0; m_ecc = 0;
        end else begin
            bit ev, wr;
            ev = edge_sel_i ? (hist[2] && !hist[1]) : (!hist[2] && hist[1]);
            wr = sel_i && wr_i;
            m_edge = ev          || (m_edge && !(wr && wdata_i[4]));
            m_prot = prot_viol_i || (m_prot && !(wr && wdata_i[5]));
            m_ecc  = ecc_done_i  || (m_ecc  && !(wr && wdata_i[6]));
            hist.push_front(rb_pin_i);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit ie;
        chk("R1 ready/busy bit", 32'(rdata_o[0]), 32'(hist[1]));
        chk("R2 chip-enable bits", 32'(rdata_o[3:2]), 32'(ce_lvl_i));
        chk("R3 transition flag", 32'(rdata_o[4]), 32'(m_edge));
        chk("R4 violation flag", 32'(rdata_o[5]), 32'(m_prot));
        chk("R5 ecc flag", 32'(rdata_o[6]), 32'(m_ecc));
        chk("R6 boot bit", 32'(rdata_o[23]), 32'(boot_done_i));
        chk("R9 reserved bits", rdata_o & 32'hFF7F_FF82, 32'h0);
        ie = (m_edge && irq_en_i[0]) || (m_prot && irq_en_i[1]) || (m_ecc && irq_en_i[2]);
        chk("R10 interrupt", 32'(irq_o), 32'(ie));
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr1(input logic [31:0] d);
        sel_i = 1; wr_i = 1; wdata_i = d;
        cyc();
        sel_i = 0; wr_i = 0; wdata_i = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        // R11: reset state
        cyc(3);
        chk("R11 reset word", rdata_o, 32'h0000_000D);
        rst_n = 1;
        cyc(3);
        chk("R11 no event after reset", 32'(rdata_o[4]), 0);

        // R3: rising mode; falling edge must not set
        rb_pin_i = 0; cyc(4);
        chk("R3 falling ignored in rising mode", 32'(rdata_o[4]), 0);
        chk("R1 busy seen", 32'(rdata_o[0]), 0);
        rb_pin_i = 1; cyc(1);
        chk("R1 two-edge latency", 32'(rdata_o[0]), 0);
        cyc(1);
        chk("R1 level after sync", 32'(rdata_o[0]), 1);
        cyc(1);
        chk("R3 rising sets flag", 32'(rdata_o[4]), 1);

        // R7: write 0 leaves, write 1 clears
        wr1(32'h0);
        chk("R7 zero write keeps flag", 32'(rdata_o[4]), 1);
        wr1(32'h10);
        chk("R7 clear transition flag", 32'(rdata_o[4]), 0);

        // R3: falling mode
        edge_sel_i = 1;
        rb_pin_i = 0; cyc(4);
        chk("R3 falling sets in falling mode", 32'(rdata_o[4]), 1);
        wr1(32'h10);
        rb_pin_i = 1; cyc(4);
        chk("R3 rising ignored in falling mode", 32'(rdata_o[4]), 0);
        edge_sel_i = 0;

        // R4/R5/R10
        ecc_done_i = 1; cyc(); ecc_done_i = 0;
        chk("R5 ecc flag set", 32'(rdata_o[6]), 1);
        chk("R10 disabled no irq", 32'(irq_o), 0);
        irq_en_i = 3'b100; cyc();
        chk("R10 ecc enabled irq", 32'(irq_o), 1);
        prot_viol_i = 1; cyc(); prot_viol_i = 0;
        chk("R4 violation flag set", 32'(rdata_o[5]), 1);
        wr1(32'h40);
        chk("R10 irq drops on clear", 32'(irq_o), 0);
        irq_en_i = 3'b010; cyc();
        chk("R10 violation enabled irq", 32'(irq_o), 1);

        // R8: set wins
        ecc_done_i = 1; wr1(32'h40); ecc_done_i = 0;
        chk("R8 set beats clear", 32'(rdata_o[6]), 1);

        // R9: writes to read-only and reserved bits
        wr1(32'hFFFF_FF8F);
        chk("R9 flags untouched by other bits", 32'(rdata_o[6:4]), 3'b110);

        // R2/R6
        ce_lvl_i = 2'b01; boot_done_i = 1; cyc();
        chk("R2 ce mirror", 32'(rdata_o[3:2]), 2'b01);
        chk("R6 boot mirror", 32'(rdata_o[23]), 1);
        wr1(32'h70);
        chk("R7 clear all flags", 32'(rdata_o[6:4]), 0);

        // random run
        lfsr = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rb_pin_i    = (lfsr[2:0] == 0) ? ~rb_pin_i : rb_pin_i;
            ce_lvl_i    = lfsr[4:3];
            boot_done_i = lfsr[5];
            ecc_done_i  = lfsr[9:6] == 0;
            prot_viol_i = lfsr[13:10] == 0;
            edge_sel_i  = (k / 300) % 2 == 1;
            irq_en_i    = lfsr[14:12];
            sel_i       = lfsr[7];
            wr_i        = lfsr[11];
            wdata_i     = {lfsr, lfsr[0] ? lfsr : ~lfsr};
            cyc();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule